// File: doc/BRIEF.md
# Accelerator Control and Statistics Register Block

This block is the software-visible register file of a packet-processing accelerator. It sits behind a simple single-cycle register port (write strobe, read strobe, byte offset, 32-bit write data, registered read data). Software uses it to launch and abort runs, read the accelerator's idle and error state, and read event statistics. It also uses it to program the network identity and the data-collection settings that the datapath consumes.

Eight saturating event counters, each `CNT_W` bits wide, count single-cycle pulses from the datapath. Software reads each counter as a low word and a high word. A read of the low word freezes the upper bits into a per-counter shadow, so that a later read of the high word pairs correctly with the low word already read. Counters fall into two clearing groups. The run-scoped group (processed packets and the two stall counters) clears when software issues a start. The network group (Ethernet, ICMP, UDP, detector packets and MAC errors) clears only on reset or while software holds the clear-network-counters bit. Configuration values are driven straight out of the block as ports.

Top module: `accel_csr`

## Requirements
- R1: After reset, start_o and cancel_o are 0, all configuration outputs are 0, every counter reads 0, and the control word reads only its live status bits.
- R2: Writing the control word (offset 0x00) with bit 0 set drives start_o high for exactly the cycle after the write. Control bit 0 then reads 1 until a cycle in which idle_i is 0 has passed.
- R3: Control bit 2 (cancel, also driven on cancel_o) and bit 3 (clear network counters) are read/write. A write with bit 0 set returns both to 0, even when the same write sets them.
- R4: Control bit 1 reads idle_i, bit 4 reads host_wr_idle_i and bit 7 reads the INSTANCE parameter. Writes to these bits have no effect.
- R5: Control bits 24 to 27 record any 1 seen on host_wr_err_i[3:0] and keep it until a write with bit 0 set, which clears them.
- R6: Counter k (0 processed, 1 host-write stall, 2 memory stall, 3 Ethernet, 4 ICMP, 5 UDP, 6 detector, 7 MAC error) increments by one for each cycle that evt_i[k] is 1. Its low word (bits LO_W-1:0) is at 0x40+8k and its high word (bits CNT_W-1:LO_W) is at 0x44+8k, both zero-extended. A pulse is visible to a read issued in the next cycle.
- R7: A write with control bit 0 set clears counters 0 to 2 and leaves counters 3 to 7 unchanged.
- R8: While control bit 3 is 1, counters 3 to 7 are held at 0 from the second clock edge after the write that sets it. Counters 0 to 2 are unaffected. Counting resumes once the bit is 0.
- R9: A counter that reaches 2^CNT_W-1 stays there instead of wrapping.
- R10: A read of a counter's low word captures its high bits into a shadow. Reads of the high word return the shadow, even if the counter has since moved.
- R11: The configuration registers are read/write and drive their outputs directly. Unused bits read 0. The layout is: MAC bits 31:0 at 0x80; MAC bits 47:32 in bits 15:0 at 0x84; IPv4 at 0x88; module count (MOD_W bits) at 0x8C. The mode word at 0x90 holds photon conversion in bit 0 and the collection id in bits 31:16. The 12.24 energy reciprocal has bits 31:0 at 0x94 and bits 35:32 at 0x98. The expected frame count is at 0x9C, the photon threshold at 0xA0, and the 6.4 signal-to-noise threshold in bits 9:0 at 0xA4.
- R12: Reads of unmapped, reserved or misaligned offsets return 0. Writes to them and to counter offsets change nothing.
- R13: rdata_o is loaded on the clock edge that samples rd_en_i and holds its value while rd_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| idle_i | input | 1 | Datapath idle |
| host_wr_idle_i | input | 1 | Host memory writer idle |
| host_wr_err_i | input | ERR_W | Host memory writer error pulses |
| evt_i | input | 8 | Event pulses, one per counter |
| start_o | output | 1 | Single-cycle start pulse |
| cancel_o | output | 1 | Cancel request level |
| mac_addr_o | output | 48 | MAC address |
| ipv4_addr_o | output | 32 | IPv4 address |
| num_modules_o | output | MOD_W | Number of detector modules |
| photon_conv_o | output | 1 | Photon conversion enable |
| collection_id_o | output | 16 | Data collection identifier |
| inv_energy_o | output | ENERGY_INT_W+ENERGY_FRAC_W | Energy reciprocal, unsigned fixed point |
| frames_expected_o | output | 32 | Expected frame count |
| photon_thresh_o | output | 32 | Photon count threshold |
| snr_thresh_o | output | SNR_INT_W+SNR_FRAC_W | Signal-to-noise threshold, unsigned fixed point |

## Verification
Results fall due at fixed distances from a stimulus. Read data and the start pulse appear after the one edge that samples the strobe. A counter pulse is seen by a read issued in the following cycle. The network-counter clear is seen only from the second edge after its write. The bench drives every input on a falling edge and samples on the following falling edge; for the clear, it inserts one idle cycle before reading. A small configuration (12-bit counters split at bit 6) makes saturation and the split between the low and high words reachable. This lets the shadow be checked with a counter whose high bits move between the two reads.

// File: rtl/accel_csr_pkg.sv
`timescale 1ns/1ps
package accel_csr_pkg;

   localparam int NUM_CNT = 8;
   localparam int IDX_W   = $clog2(NUM_CNT);

   typedef enum logic [IDX_W-1:0] {
      CNT_PROC       = 3'd0,
      CNT_STALL_HOST = 3'd1,
      CNT_STALL_MEM  = 3'd2,
      CNT_ETH        = 3'd3,
      CNT_ICMP       = 3'd4,
      CNT_UDP        = 3'd5,
      CNT_DET        = 3'd6,
      CNT_MAC_ERR    = 3'd7
   } cnt_idx_e;

   // Clearing groups: run-scoped counters clear on start, network counters on clear bit
   localparam logic [NUM_CNT-1:0] RUN_GROUP = 8'b0000_0111;
   localparam logic [NUM_CNT-1:0] NET_GROUP = 8'b1111_1000;

   // Control word bit positions
   localparam int CB_START   = 0;
   localparam int CB_IDLE    = 1;
   localparam int CB_CANCEL  = 2;
   localparam int CB_NETCLR  = 3;
   localparam int CB_HWIDLE  = 4;
   localparam int CB_INST    = 7;
   localparam int CB_ERR_LSB = 24;

   // Byte offsets
   localparam int OFS_CTRL      = 'h00;
   localparam int OFS_CNT_BASE  = 'h40;
   localparam int CNT_SPAN      = NUM_CNT * 8;
   localparam int OFS_MAC_LO    = 'h80;
   localparam int OFS_MAC_HI    = 'h84;
   localparam int OFS_IPV4      = 'h88;
   localparam int OFS_MODULES   = 'h8C;
   localparam int OFS_MODE      = 'h90;
   localparam int OFS_ENERGY_LO = 'h94;
   localparam int OFS_ENERGY_HI = 'h98;
   localparam int OFS_FRAMES    = 'h9C;
   localparam int OFS_PHOT_THR  = 'hA0;
   localparam int OFS_SNR_THR   = 'hA4;
   localparam int OFS_LAST      = OFS_SNR_THR;

endpackage

// File: rtl/accel_csr_counter.sv
`timescale 1ns/1ps
module accel_csr_counter #(
   parameter int CNT_W = 64,
   parameter int LO_W  = 32,
   localparam int HI_W = CNT_W - LO_W
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            inc_i,
   input  logic            clr_i,
   input  logic            snap_i,
   output logic [LO_W-1:0] lo_o,
   output logic [HI_W-1:0] shadow_hi_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (LO_W < 1 || LO_W > 32) begin : g_bad_lo
      $error("accel_csr_counter: LO_W must lie in 1..32");
   end
   if (HI_W < 1 || HI_W > 32) begin : g_bad_hi
      $error("accel_csr_counter: CNT_W-LO_W must lie in 1..32");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [HI_W-1:0]  shadow_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shadow_q <= '0;
      end else if (snap_i) begin
         shadow_q <= cnt_q[CNT_W-1:LO_W];
      end
   end

   assign lo_o        = cnt_q[LO_W-1:0];
   assign shadow_hi_o = shadow_q;

   // R9: a saturated counter stays saturated
   a_r9_saturate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cnt_q == CNT_MAX) && !clr_i) |=> (cnt_q == CNT_MAX));

   // R6: without clear the counter moves by at most one per cycle
   a_r6_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

   // R6: no event, no change
   a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !inc_i) |=> $stable(cnt_q));

   // R7 / R8: a clear leaves zero behind
   a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

   // R10: the shadow only moves on a low-word read
   a_r10_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !snap_i |=> $stable(shadow_q));

endmodule

// File: rtl/accel_csr_ctrl.sv
`timescale 1ns/1ps
module accel_csr_ctrl
   import accel_csr_pkg::*;
#(
   parameter int INSTANCE = 0,
   parameter int ERR_W    = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic             wr_start_i,
   input  logic             wr_cancel_i,
   input  logic             wr_netclr_i,
   input  logic             idle_i,
   input  logic             host_wr_idle_i,
   input  logic [ERR_W-1:0] host_wr_err_i,
   output logic [31:0]      ctrl_word_o,
   output logic             start_evt_o,
   output logic             start_o,
   output logic             cancel_o,
   output logic             netclr_o
);

   if (INSTANCE < 0 || INSTANCE > 1) begin : g_bad_inst
      $error("accel_csr_ctrl: INSTANCE must be 0 or 1");
   end
   if (ERR_W < 1 || CB_ERR_LSB + ERR_W > 32) begin : g_bad_err
      $error("accel_csr_ctrl: error field does not fit the control word");
   end

   logic             start_evt;
   logic             start_q;
   logic             pulse_q;
   logic             cancel_q;
   logic             netclr_q;
   logic [ERR_W-1:0] err_q;

   assign start_evt = wr_i && wr_start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q  <= 1'b0;
         pulse_q  <= 1'b0;
         cancel_q <= 1'b0;
         netclr_q <= 1'b0;
         err_q    <= '0;
      end else begin
         pulse_q <= start_evt;
         if (start_evt) begin
            start_q <= 1'b1;
         end else if (start_q && !idle_i) begin
            start_q <= 1'b0;
         end
         if (start_evt) begin
            cancel_q <= 1'b0;
            netclr_q <= 1'b0;
            err_q    <= '0;
         end else begin
            if (wr_i) begin
               cancel_q <= wr_cancel_i;
               netclr_q <= wr_netclr_i;
            end
            err_q <= err_q | host_wr_err_i;
         end
      end
   end

   always_comb begin
      ctrl_word_o                          = '0;
      ctrl_word_o[CB_START]                = start_q;
      ctrl_word_o[CB_IDLE]                 = idle_i;
      ctrl_word_o[CB_CANCEL]               = cancel_q;
      ctrl_word_o[CB_NETCLR]               = netclr_q;
      ctrl_word_o[CB_HWIDLE]               = host_wr_idle_i;
      ctrl_word_o[CB_INST]                 = (INSTANCE == 1);
      ctrl_word_o[CB_ERR_LSB +: ERR_W]     = err_q;
   end

   assign start_evt_o = start_evt;
   assign start_o     = pulse_q;
   assign cancel_o    = cancel_q;
   assign netclr_o    = netclr_q;

   // R3: a start leaves cancel and clear at zero
   a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_evt |=> (!cancel_q && !netclr_q));

   // R5: error flags are sticky until a start
   a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_evt |=> ((err_q & $past(err_q)) == $past(err_q)));

   // R5: a start empties the error flags
   a_r5_err_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_evt |=> (err_q == '0));

   // R2: the start bit holds while the datapath stays idle
   a_r2_start_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_q && idle_i) |=> start_q);

   // R2: each pulse follows a start write and is not repeated without one
   a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_q && !start_evt) |=> !pulse_q);

endmodule

// File: rtl/accel_csr_cfg.sv
`timescale 1ns/1ps
module accel_csr_cfg
   import accel_csr_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int MOD_W    = 8,
   parameter int ENERGY_W = 36,
   parameter int SNR_W    = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [31:0]         wdata_i,
   output logic                hit_o,
   output logic [31:0]         rdata_o,
   output logic [47:0]         mac_addr_o,
   output logic [31:0]         ipv4_addr_o,
   output logic [MOD_W-1:0]    num_modules_o,
   output logic                photon_conv_o,
   output logic [15:0]         collection_id_o,
   output logic [ENERGY_W-1:0] inv_energy_o,
   output logic [31:0]         frames_expected_o,
   output logic [31:0]         photon_thresh_o,
   output logic [SNR_W-1:0]    snr_thresh_o
);

   localparam int E_LO_W = (ENERGY_W > 32) ? 32 : ENERGY_W;
   localparam int E_HI_W = (ENERGY_W > 32) ? ENERGY_W - 32 : 1;

   if (MOD_W < 1 || MOD_W > 32) begin : g_bad_mod
      $error("accel_csr_cfg: MOD_W must lie in 1..32");
   end
   if (ENERGY_W < 1 || ENERGY_W > 64) begin : g_bad_energy
      $error("accel_csr_cfg: energy width must lie in 1..64");
   end
   if (SNR_W < 1 || SNR_W > 32) begin : g_bad_snr
      $error("accel_csr_cfg: threshold width must lie in 1..32");
   end

   function automatic logic is_at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [31:0]       mac_lo_q;
   logic [15:0]       mac_hi_q;
   logic [31:0]       ipv4_q;
   logic [MOD_W-1:0]  modules_q;
   logic              photon_q;
   logic [15:0]       coll_id_q;
   logic [E_LO_W-1:0] e_lo_q;
   logic [31:0]       frames_q;
   logic [31:0]       phot_thr_q;
   logic [SNR_W-1:0]  snr_q;

   logic              e_hi_hit;
   logic [31:0]       e_hi_rd;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mac_lo_q   <= '0;
         mac_hi_q   <= '0;
         ipv4_q     <= '0;
         modules_q  <= '0;
         photon_q   <= 1'b0;
         coll_id_q  <= '0;
         e_lo_q     <= '0;
         frames_q   <= '0;
         phot_thr_q <= '0;
         snr_q      <= '0;
      end else if (wr_i) begin
         if (is_at(addr_i, OFS_MAC_LO))    mac_lo_q   <= wdata_i;
         if (is_at(addr_i, OFS_MAC_HI))    mac_hi_q   <= wdata_i[15:0];
         if (is_at(addr_i, OFS_IPV4))      ipv4_q     <= wdata_i;
         if (is_at(addr_i, OFS_MODULES))   modules_q  <= wdata_i[MOD_W-1:0];
         if (is_at(addr_i, OFS_MODE)) begin
            photon_q  <= wdata_i[0];
            coll_id_q <= wdata_i[31:16];
         end
         if (is_at(addr_i, OFS_ENERGY_LO)) e_lo_q     <= wdata_i[E_LO_W-1:0];
         if (is_at(addr_i, OFS_FRAMES))    frames_q   <= wdata_i;
         if (is_at(addr_i, OFS_PHOT_THR))  phot_thr_q <= wdata_i;
         if (is_at(addr_i, OFS_SNR_THR))   snr_q      <= wdata_i[SNR_W-1:0];
      end
   end

   // Wide energy formats take a second word, narrow ones leave it unmapped
   if (ENERGY_W > 32) begin : g_energy_wide
      logic [E_HI_W-1:0] e_hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            e_hi_q <= '0;
         end else if (wr_i && is_at(addr_i, OFS_ENERGY_HI)) begin
            e_hi_q <= wdata_i[E_HI_W-1:0];
         end
      end
      assign inv_energy_o = {e_hi_q, e_lo_q};
      assign e_hi_hit     = is_at(addr_i, OFS_ENERGY_HI);
      assign e_hi_rd      = 32'(e_hi_q);
   end else begin : g_energy_narrow
      assign inv_energy_o = e_lo_q;
      assign e_hi_hit     = 1'b0;
      assign e_hi_rd      = '0;
   end

   always_comb begin
      hit_o   = 1'b1;
      rdata_o = '0;
      if (is_at(addr_i, OFS_MAC_LO))          rdata_o = mac_lo_q;
      else if (is_at(addr_i, OFS_MAC_HI))     rdata_o = 32'(mac_hi_q);
      else if (is_at(addr_i, OFS_IPV4))       rdata_o = ipv4_q;
      else if (is_at(addr_i, OFS_MODULES))    rdata_o = 32'(modules_q);
      else if (is_at(addr_i, OFS_MODE))       rdata_o = {coll_id_q, 15'd0, photon_q};
      else if (is_at(addr_i, OFS_ENERGY_LO))  rdata_o = 32'(e_lo_q);
      else if (e_hi_hit)                      rdata_o = e_hi_rd;
      else if (is_at(addr_i, OFS_FRAMES))     rdata_o = frames_q;
      else if (is_at(addr_i, OFS_PHOT_THR))   rdata_o = phot_thr_q;
      else if (is_at(addr_i, OFS_SNR_THR))    rdata_o = 32'(snr_q);
      else                                    hit_o   = 1'b0;
   end

   assign mac_addr_o        = {mac_hi_q, mac_lo_q};
   assign ipv4_addr_o       = ipv4_q;
   assign num_modules_o     = modules_q;
   assign photon_conv_o     = photon_q;
   assign collection_id_o   = coll_id_q;
   assign frames_expected_o = frames_q;
   assign photon_thresh_o   = phot_thr_q;
   assign snr_thresh_o      = snr_q;

   // R11: without a write the outputs do not move
   a_r11_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> ($stable(mac_addr_o) && $stable(ipv4_addr_o) && $stable(inv_energy_o)
                 && $stable(snr_thresh_o) && $stable(collection_id_o)));

endmodule

// File: rtl/accel_csr.sv
`timescale 1ns/1ps
module accel_csr
   import accel_csr_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int CNT_W         = 64,
   parameter int LO_W          = 32,
   parameter int INSTANCE      = 0,
   parameter int ERR_W         = 4,
   parameter int MOD_W         = 8,
   parameter int ENERGY_INT_W  = 12,
   parameter int ENERGY_FRAC_W = 24,
   parameter int SNR_INT_W     = 6,
   parameter int SNR_FRAC_W    = 4
) (
   input  logic                                  clk_i,
   input  logic                                  rst_ni,
   input  logic                                  wr_en_i,
   input  logic                                  rd_en_i,
   input  logic [ADDR_W-1:0]                     addr_i,
   input  logic [31:0]                           wdata_i,
   output logic [31:0]                           rdata_o,
   input  logic                                  idle_i,
   input  logic                                  host_wr_idle_i,
   input  logic [ERR_W-1:0]                      host_wr_err_i,
   input  logic [7:0]                            evt_i,
   output logic                                  start_o,
   output logic                                  cancel_o,
   output logic [47:0]                           mac_addr_o,
   output logic [31:0]                           ipv4_addr_o,
   output logic [MOD_W-1:0]                      num_modules_o,
   output logic                                  photon_conv_o,
   output logic [15:0]                           collection_id_o,
   output logic [ENERGY_INT_W+ENERGY_FRAC_W-1:0] inv_energy_o,
   output logic [31:0]                           frames_expected_o,
   output logic [31:0]                           photon_thresh_o,
   output logic [SNR_INT_W+SNR_FRAC_W-1:0]       snr_thresh_o
);

   localparam int ENERGY_W = ENERGY_INT_W + ENERGY_FRAC_W;
   localparam int SNR_W    = SNR_INT_W + SNR_FRAC_W;
   localparam int HI_W     = CNT_W - LO_W;

   if (ADDR_W < $clog2(OFS_LAST + 4)) begin : g_bad_addr
      $error("accel_csr: ADDR_W too narrow for the register map");
   end
   if (NUM_CNT != 8) begin : g_bad_cnt
      $error("accel_csr: event port assumes eight counters");
   end

   // ---------------- decode ----------------
   logic              ctrl_sel;
   logic [ADDR_W-1:0] cnt_off;
   logic              cnt_sel;
   logic [IDX_W-1:0]  cnt_idx;
   logic              cnt_hi_sel;

   assign ctrl_sel   = (addr_i == ADDR_W'(OFS_CTRL));
   assign cnt_off    = addr_i - ADDR_W'(OFS_CNT_BASE);
   assign cnt_sel    = (cnt_off < ADDR_W'(CNT_SPAN)) && (cnt_off[1:0] == 2'b00);
   assign cnt_idx    = cnt_off[IDX_W+2:3];
   assign cnt_hi_sel = cnt_off[2];

   // ---------------- control word ----------------
   logic [31:0] ctrl_word;
   logic        start_evt;
   logic        netclr;

   accel_csr_ctrl #(
      .INSTANCE (INSTANCE),
      .ERR_W    (ERR_W)
   ) u_ctrl (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (wr_en_i && ctrl_sel),
      .wr_start_i     (wdata_i[CB_START]),
      .wr_cancel_i    (wdata_i[CB_CANCEL]),
      .wr_netclr_i    (wdata_i[CB_NETCLR]),
      .idle_i         (idle_i),
      .host_wr_idle_i (host_wr_idle_i),
      .host_wr_err_i  (host_wr_err_i),
      .ctrl_word_o    (ctrl_word),
      .start_evt_o    (start_evt),
      .start_o        (start_o),
      .cancel_o       (cancel_o),
      .netclr_o       (netclr)
   );

   // ---------------- event counters ----------------
   logic [NUM_CNT-1:0] snap;
   logic [LO_W-1:0]    cnt_lo [NUM_CNT];
   logic [HI_W-1:0]    cnt_sh [NUM_CNT];

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic clr;
      assign clr = (RUN_GROUP[k] && start_evt) || (NET_GROUP[k] && netclr);
      accel_csr_counter #(
         .CNT_W (CNT_W),
         .LO_W  (LO_W)
      ) u_cnt (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .inc_i       (evt_i[k]),
         .clr_i       (clr),
         .snap_i      (snap[k]),
         .lo_o        (cnt_lo[k]),
         .shadow_hi_o (cnt_sh[k])
      );
   end

   // ---------------- configuration ----------------
   logic        cfg_hit;
   logic [31:0] cfg_rdata;

   accel_csr_cfg #(
      .ADDR_W   (ADDR_W),
      .MOD_W    (MOD_W),
      .ENERGY_W (ENERGY_W),
      .SNR_W    (SNR_W)
   ) u_cfg (
      .clk_i             (clk_i),
      .rst_ni            (rst_ni),
      .wr_i              (wr_en_i),
      .addr_i            (addr_i),
      .wdata_i           (wdata_i),
      .hit_o             (cfg_hit),
      .rdata_o           (cfg_rdata),
      .mac_addr_o        (mac_addr_o),
      .ipv4_addr_o       (ipv4_addr_o),
      .num_modules_o     (num_modules_o),
      .photon_conv_o     (photon_conv_o),
      .collection_id_o   (collection_id_o),
      .inv_energy_o      (inv_energy_o),
      .frames_expected_o (frames_expected_o),
      .photon_thresh_o   (photon_thresh_o),
      .snr_thresh_o      (snr_thresh_o)
   );

   // ---------------- read path ----------------
   logic        rd_hit;
   logic [31:0] rd_word;
   logic [31:0] rdata_q;

   always_comb begin
      rd_hit  = 1'b0;
      rd_word = '0;
      snap    = '0;
      if (ctrl_sel) begin
         rd_hit  = 1'b1;
         rd_word = ctrl_word;
      end else if (cnt_sel) begin
         rd_hit = 1'b1;
         if (cnt_hi_sel) begin
            rd_word = 32'(cnt_sh[cnt_idx]);
         end else begin
            rd_word       = 32'(cnt_lo[cnt_idx]);
            snap[cnt_idx] = rd_en_i;
         end
      end else if (cfg_hit) begin
         rd_hit  = 1'b1;
         rd_word = cfg_rdata;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         rdata_q <= rd_word;
      end
   end

   assign rdata_o = rdata_q;

   // R12: unmapped reads return zero
   a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !rd_hit) |=> (rdata_o == '0));

   // R13: read data holds between reads
   a_r13_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));

   // R10: at most one shadow captures per cycle
   a_r10_one_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(snap));

endmodule

// File: tb/tb_accel_csr.sv
`timescale 1ns/1ps
module tb_accel_csr;

   localparam int CW = 12;
   localparam int LW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        idle = 1'b1;
   logic        hw_idle = 1'b0;
   logic [3:0]  hw_err = '0;
   logic [7:0]  evt = '0;
   logic        start;
   logic        cancel;
   logic [47:0] mac;
   logic [31:0] ipv4;
   logic [7:0]  nmod;
   logic        phot;
   logic [15:0] cid;
   logic [35:0] inv_e;
   logic [31:0] frames;
   logic [31:0] pthr;
   logic [9:0]  snr;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   accel_csr #(
      .ADDR_W   (8),
      .CNT_W    (CW),
      .LO_W     (LW),
      .INSTANCE (1)
   ) dut (
      .clk_i             (clk),
      .rst_ni            (rst_n),
      .wr_en_i           (wr_en),
      .rd_en_i           (rd_en),
      .addr_i            (addr),
      .wdata_i           (wdata),
      .rdata_o           (rdata),
      .idle_i            (idle),
      .host_wr_idle_i    (hw_idle),
      .host_wr_err_i     (hw_err),
      .evt_i             (evt),
      .start_o           (start),
      .cancel_o          (cancel),
      .mac_addr_o        (mac),
      .ipv4_addr_o       (ipv4),
      .num_modules_o     (nmod),
      .photon_conv_o     (phot),
      .collection_id_o   (cid),
      .inv_energy_o      (inv_e),
      .frames_expected_o (frames),
      .photon_thresh_o   (pthr),
      .snr_thresh_o      (snr)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // All tasks start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input int k, input int n);
      for (int i = 0; i < n; i++) begin
         evt[k] = 1'b1;
         @(negedge clk);
      end
      evt = '0;
   endtask

   task automatic drop_idle();
      idle = 1'b0;
      @(negedge clk);
      idle = 1'b1;
   endtask

   function automatic logic [31:0] ectl(input logic st, input logic cn, input logic cl,
                                        input logic [3:0] er);
      return 32'(st) | (32'(idle) << 1) | (32'(cn) << 2) | (32'(cl) << 3)
           | (32'(hw_idle) << 4) | (32'd1 << 7) | (32'(er) << 24);
   endfunction

   function automatic logic [31:0] cv(input logic [7:0] a, input logic [31:0] p);
      return p ^ (32'(a) * 32'h0101_0101);
   endfunction

   logic [7:0]  cfg_a [10] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4};
   logic [31:0] cfg_m [10] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_00FF,
                               32'hFFFF_0001, 32'hFFFF_FFFF, 32'h0000_000F, 32'hFFFF_FFFF,
                               32'hFFFF_FFFF, 32'h0000_03FF};

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(8'h00, d);
      chk("R1 ctrl after reset", d, ectl(0, 0, 0, 4'h0));
      chk("R1 start_o", start, 0);
      chk("R1 cancel_o", cancel, 0);
      chk("R1 mac", mac, 0);
      chk("R1 energy", inv_e, 0);
      rd(8'h48, d);
      chk("R1 counter low", d, 0);

      // R4: read-only status bits follow inputs, writes ignored
      idle = 1'b0; hw_idle = 1'b1;
      wr(8'h00, 32'h0000_0092);
      rd(8'h00, d);
      chk("R4 status bits", d, ectl(0, 0, 0, 4'h0));
      idle = 1'b1; hw_idle = 1'b0;
      rd(8'h00, d);
      chk("R4 status bits flipped", d, ectl(0, 0, 0, 4'h0));

      // R6: each counter counts its own events, then all at once
      for (int k = 0; k < 8; k++) pulse(k, k + 3);
      for (int k = 0; k < 8; k++) begin
         rd(8'(8'h40 + 8 * k), d);
         chk($sformatf("R6 counter %0d low", k), d, k + 3);
         rd(8'(8'h44 + 8 * k), d);
         chk($sformatf("R6 counter %0d high", k), d, 0);
      end
      for (int i = 0; i < 5; i++) begin
         evt = 8'hFF;
         @(negedge clk);
      end
      evt = '0;
      for (int k = 0; k < 8; k++) begin
         rd(8'(8'h40 + 8 * k), d);
         chk($sformatf("R6 counter %0d after burst", k), d, k + 8);
      end

      // R2 / R7: start pulse, start bit, run-group clear
      wr(8'h00, 32'h1);
      chk("R2 start pulse high", start, 1);
      @(negedge clk);
      chk("R2 start pulse single", start, 0);
      rd(8'h00, d);
      chk("R2 start bit held", d, ectl(1, 0, 0, 4'h0));
      for (int k = 0; k < 8; k++) begin
         rd(8'(8'h40 + 8 * k), d);
         chk($sformatf("R7 counter %0d after start", k), d, (k < 3) ? 0 : k + 8);
      end
      drop_idle();
      rd(8'h00, d);
      chk("R2 start bit released", d, ectl(0, 0, 0, 4'h0));

      // R3 / R8: cancel and network clear
      pulse(0, 3);
      wr(8'h00, 32'h0000_000C);
      chk("R3 cancel_o set", cancel, 1);
      @(negedge clk);
      rd(8'h00, d);
      chk("R3 cancel and clear read back", d, ectl(0, 1, 1, 4'h0));
      rd(8'h40, d);
      chk("R8 run counter untouched", d, 3);
      rd(8'h68, d);
      chk("R8 network counter cleared", d, 0);
      pulse(5, 4);
      rd(8'h68, d);
      chk("R8 network counter held", d, 0);
      wr(8'h00, 32'h0000_000D);
      rd(8'h00, d);
      chk("R3 start clears cancel and clear", d, ectl(1, 0, 0, 4'h0));
      chk("R3 cancel_o cleared", cancel, 0);
      rd(8'h40, d);
      chk("R7 run counter cleared", d, 0);
      pulse(5, 2);
      rd(8'h68, d);
      chk("R8 counting resumes", d, 2);
      drop_idle();

      // R5: sticky errors
      hw_err = 4'b0101;
      @(negedge clk);
      hw_err = 4'b0010;
      @(negedge clk);
      hw_err = 4'b0000;
      rd(8'h00, d);
      chk("R5 errors sticky", d, ectl(0, 0, 0, 4'b0111));
      wr(8'h00, 32'h0);
      rd(8'h00, d);
      chk("R5 errors survive write", d, ectl(0, 0, 0, 4'b0111));
      wr(8'h00, 32'h1);
      rd(8'h00, d);
      chk("R5 errors cleared by start", d, ectl(1, 0, 0, 4'h0));
      drop_idle();

      // R9: saturation
      pulse(3, 4100);
      rd(8'h58, d);
      chk("R9 saturated low", d, 63);
      rd(8'h5C, d);
      chk("R9 saturated high", d, 63);

      // R10: shadow capture
      pulse(4, 70);
      rd(8'h60, d);
      chk("R10 low word", d, 70 % 64);
      pulse(4, 64);
      rd(8'h64, d);
      chk("R10 high from shadow", d, 70 / 64);
      rd(8'h60, d);
      chk("R10 low word again", d, 134 % 64);
      rd(8'h64, d);
      chk("R10 high recaptured", d, 134 / 64);

      // R11: configuration sweep with two patterns
      for (int p = 0; p < 2; p++) begin
         logic [31:0] pat;
         pat = (p == 0) ? 32'hDEAD_BEEF : 32'h3C96_0FF1;
         for (int i = 0; i < 10; i++) wr(cfg_a[i], cv(cfg_a[i], pat));
         for (int i = 0; i < 10; i++) begin
            rd(cfg_a[i], d);
            chk($sformatf("R11 readback %0h", cfg_a[i]), d, cv(cfg_a[i], pat) & cfg_m[i]);
         end
         chk("R11 mac out", mac, {cv(8'h84, pat)[15:0], cv(8'h80, pat)});
         chk("R11 ipv4 out", ipv4, cv(8'h88, pat));
         chk("R11 modules out", nmod, cv(8'h8C, pat)[7:0]);
         chk("R11 photon out", phot, cv(8'h90, pat)[0]);
         chk("R11 collection id out", cid, cv(8'h90, pat)[31:16]);
         chk("R11 energy out", inv_e, {cv(8'h98, pat)[3:0], cv(8'h94, pat)});
         chk("R11 frames out", frames, cv(8'h9C, pat));
         chk("R11 photon threshold out", pthr, cv(8'hA0, pat));
         chk("R11 snr out", snr, cv(8'hA4, pat)[9:0]);
      end

      // R12: unmapped, misaligned, counter writes
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'hA8, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      wr(8'h42, 32'hFFFF_FFFF);
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h82, 32'hFFFF_FFFF);
      rd(8'h04, d); chk("R12 reserved 04", d, 0);
      rd(8'h3C, d); chk("R12 reserved 3C", d, 0);
      rd(8'hA8, d); chk("R12 past map A8", d, 0);
      rd(8'hFC, d); chk("R12 top FC", d, 0);
      rd(8'h42, d); chk("R12 misaligned 42", d, 0);
      rd(8'h48, d); chk("R12 counter write ignored", d, 0);
      rd(8'h80, d); chk("R12 misaligned write ignored", d, cv(8'h80, 32'h3C96_0FF1));

      // R13: read data holds
      rd(8'h88, held);
      addr = 8'h00;
      @(negedge clk);
      addr = 8'h90;
      @(negedge clk);
      chk("R13 rdata holds", rdata, held);
      chk("R13 held value", held, cv(8'h88, 32'h3C96_0FF1));

      finish_run();
   end

endmodule